// File: doc/BRIEF.md
# Row Skip Pre-Processor for a Separable Transform Stage

This block sits in front of one 1D transform stage in a separable 3D transform pipeline. For each incoming row of eight signed samples it forms two statistics: the row sum, which stands in for the row mean, and the total of the absolute differences between neighbouring samples. From these two figures it decides whether the transform of that row can be skipped. A skipped row is predicted to carry so little energy that the quantizer would zero it anyway.

The outputs are registered. One cycle after a row is strobed in, the block returns three things: a skip flag, a transform-enable that lets the downstream stage compute only rows that are not skipped, and the row itself. That row is copied through unchanged when it is kept and forced to zero when it is skipped. The activity threshold is a 16-bit input that is sampled together with the row. A counter of skipped rows supports power-saving statistics and can be cleared with a pulse.

Top module: `rsk_row_skip`

## Requirements
- R1: `row_data` packs eight 12-bit two's-complement samples, with sample i at bits [12i+11:12i]. `out_vld` is high in exactly the cycle after each cycle in which `row_vld` is high.
- R2: A valid row whose sum is zero and whose adjacent-difference total is zero is skipped: `skip`=1 and `out_row`=0. This holds for any threshold, including 0.
- R3: A valid row whose sum is nonzero is skipped when its adjacent-difference total is strictly less than `thr`, compared as unsigned numbers using the `thr` value present in the same cycle as `row_vld`. A total equal to `thr` is not skipped.
- R4: A valid row whose sum is zero and whose adjacent-difference total is nonzero is never skipped, even with `thr`=16'hFFFF.
- R5: A valid row that is not skipped appears bit-exact on `out_row`, with `skip`=0.
- R6: `xfm_en` is high exactly when `out_vld` is high and `skip` is low.
- R7: The adjacent-difference total does not wrap for full-range rows. Alternating samples -2048/2047 give 28665, so that row is kept at `thr`=28665 and skipped at `thr`=28666.
- R8: `skip_cnt` rises by one for each skipped row, and the new value shows in the same cycle as that row's `skip`.
- R9: `cnt_clr` is synchronous. In the next cycle `skip_cnt` is 0, and a row skipped in the clear cycle is not counted.
- R10: In the cycle after a cycle with `row_vld` low, `out_vld`, `skip`, `xfm_en` and `out_row` are all 0, and `skip_cnt` is unchanged.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_vld | input | 1 | Row strobe |
| row_data | input | 96 | Eight packed signed samples |
| thr | input | 16 | Activity threshold |
| cnt_clr | input | 1 | Synchronous clear of the skip counter |
| out_vld | output | 1 | Registered row strobe |
| skip | output | 1 | Row skipped, transform result is zero |
| xfm_en | output | 1 | Downstream transform enable |
| out_row | output | 96 | Row copy, zero when skipped |
| skip_cnt | output | 16 | Number of skipped rows |

## Verification
Random samples almost never form a row whose sum is zero while its neighbours differ. Such a row must be kept whatever the threshold. Random samples also seldom form a row whose difference total lands exactly on the threshold. The stimulus builds both cases on purpose. It generates rows of mirrored pairs (a, -a, b, -b, ...) under large thresholds, and flat rows with small noise under thresholds drawn near their own difference total. It also drives directed rows at the 28665/28666 boundary of the full-range alternating pattern.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

    typedef enum logic [1:0] {
        DEC_RUN       = 2'd0,
        DEC_FLAT_ZERO = 2'd1,
        DEC_LOW_ACT   = 2'd2
    } rsk_dec_e;

endpackage

// File: rtl/rsk_row_sum.sv
module rsk_row_sum #(
    parameter int N_SMP = 8,
    parameter int SMP_W = 12,
    localparam int SUM_W = SMP_W + $clog2(N_SMP)
) (
    input  logic [N_SMP*SMP_W-1:0] row,
    output logic signed [SUM_W-1:0] sum
);

    always_comb begin
        logic signed [SMP_W-1:0] s;
        logic signed [SUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N_SMP; i++) begin
            s   = row[i*SMP_W +: SMP_W];
            acc = acc + SUM_W'(s);
        end
        sum = acc;
    end

endmodule

// File: rtl/rsk_row_sad.sv
module rsk_row_sad #(
    parameter int N_SMP = 8,
    parameter int SMP_W = 12,
    localparam int SAD_W = SMP_W + $clog2(N_SMP)
) (
    input  logic [N_SMP*SMP_W-1:0] row,
    output logic [SAD_W-1:0]       sad
);

    logic [SMP_W-1:0] mag [N_SMP-1];

    for (genvar g = 1; g < N_SMP; g++) begin : g_pair
        logic signed [SMP_W-1:0] cur;
        logic signed [SMP_W-1:0] prv;
        logic signed [SMP_W:0]   dif;
        assign cur = row[g*SMP_W +: SMP_W];
        assign prv = row[(g-1)*SMP_W +: SMP_W];
        assign dif = {cur[SMP_W-1], cur} - {prv[SMP_W-1], prv};
        assign mag[g-1] = dif[SMP_W] ? SMP_W'(-dif) : SMP_W'(dif);
    end

    always_comb begin
        logic [SAD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N_SMP - 1; i++) begin
            acc = acc + SAD_W'(mag[i]);
        end
        sad = acc;
    end

endmodule

// File: rtl/rsk_decide.sv
module rsk_decide
    import rsk_pkg::*;
#(
    parameter int SUM_W = 15,
    parameter int SAD_W = 15,
    parameter int THR_W = 16,
    localparam int CMP_W = (SAD_W > THR_W) ? SAD_W : THR_W
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic [SAD_W-1:0]        sad,
    input  logic [THR_W-1:0]        thr,
    output rsk_dec_e                dec
);

    logic [CMP_W-1:0] sad_x;
    logic [CMP_W-1:0] thr_x;
    logic             sum_zero;
    logic             sad_zero;

    assign sad_x    = CMP_W'(sad);
    assign thr_x    = CMP_W'(thr);
    assign sum_zero = (sum == '0);
    assign sad_zero = (sad == '0);

    always_comb begin
        dec = DEC_RUN;
        if (sum_zero && sad_zero) begin
            dec = DEC_FLAT_ZERO;
        end else if (!sum_zero && (sad_x < thr_x)) begin
            dec = DEC_LOW_ACT;
        end
    end

endmodule

// File: rtl/rsk_row_skip.sv
module rsk_row_skip
    import rsk_pkg::*;
#(
    parameter int N_SMP = 8,
    parameter int SMP_W = 12,
    parameter int THR_W = 16,
    parameter int CNT_W = 16,
    localparam int ROW_W = N_SMP * SMP_W,
    localparam int ACC_W = SMP_W + $clog2(N_SMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_vld,
    input  logic [ROW_W-1:0] row_data,
    input  logic [THR_W-1:0] thr,
    input  logic             cnt_clr,
    output logic             out_vld,
    output logic             skip,
    output logic             xfm_en,
    output logic [ROW_W-1:0] out_row,
    output logic [CNT_W-1:0] skip_cnt
);

    typedef struct packed {
        logic             vld;
        logic             skp;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic signed [ACC_W-1:0] row_sum;
    logic [ACC_W-1:0]        row_sad;
    rsk_dec_e                dec;

    rsk_row_sum #(.N_SMP(N_SMP), .SMP_W(SMP_W)) u_sum (
        .row (row_data),
        .sum (row_sum)
    );

    rsk_row_sad #(.N_SMP(N_SMP), .SMP_W(SMP_W)) u_sad (
        .row (row_data),
        .sad (row_sad)
    );

    rsk_decide #(.SUM_W(ACC_W), .SAD_W(ACC_W), .THR_W(THR_W)) u_dec (
        .sum (row_sum),
        .sad (row_sad),
        .thr (thr),
        .dec (dec)
    );

    always_comb begin
        logic hit;
        hit      = row_vld && (dec != DEC_RUN);
        st_d     = st_q;
        st_d.vld = row_vld;
        st_d.skp = hit;
        st_d.row = (row_vld && !hit) ? row_data : '0;
        if (cnt_clr) begin
            st_d.cnt = '0;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign skip     = st_q.skp;
    assign xfm_en   = st_q.vld && !st_q.skp;
    assign out_row  = st_q.row;
    assign skip_cnt = st_q.cnt;

endmodule

// File: rtl/rsk_row_skip_chk.sv
module rsk_row_skip_chk #(
    parameter int N_SMP = 8,
    parameter int SMP_W = 12,
    parameter int THR_W = 16,
    parameter int CNT_W = 16,
    localparam int ROW_W = N_SMP * SMP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_vld,
    input logic [ROW_W-1:0] row_data,
    input logic             cnt_clr,
    input logic             out_vld,
    input logic             skip,
    input logic             xfm_en,
    input logic [ROW_W-1:0] out_row,
    input logic [CNT_W-1:0] skip_cnt
);

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld |=> out_vld); // R1

    AST_SKIP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (out_vld && out_row == '0)); // R2

    AST_COPY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !skip) |-> (out_row == $past(row_data))); // R5

    AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        xfm_en |-> (out_vld && !skip)); // R6

    AST_GATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !skip) |-> xfm_en); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (skip_cnt == $past(skip_cnt) + CNT_W'(skip))); // R8

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (skip_cnt == '0)); // R9

    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !row_vld |=> (!out_vld && !skip && out_row == '0)); // R10

endmodule

bind rsk_row_skip rsk_row_skip_chk #(
    .N_SMP(N_SMP), .SMP_W(SMP_W), .THR_W(THR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_rsk_row_skip.sv
module sim_rsk_row_skip;

    localparam int N  = 8;
    localparam int SW = 12;
    localparam int RW = N * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_vld = 1'b0;
    logic [RW-1:0] row_data = '0;
    logic [15:0]   thr = '0;
    logic          cnt_clr = 1'b0;
    logic          out_vld;
    logic          skip;
    logic          xfm_en;
    logic [RW-1:0] out_row;
    logic [15:0]   skip_cnt;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] exp_cnt = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rsk_row_skip u0 (
        .clk(clk), .rst_n(rst_n), .row_vld(row_vld), .row_data(row_data),
        .thr(thr), .cnt_clr(cnt_clr), .out_vld(out_vld), .skip(skip),
        .xfm_en(xfm_en), .out_row(out_row), .skip_cnt(skip_cnt)
    );

    function automatic int smp(logic [RW-1:0] r, int i);
        logic signed [SW-1:0] t;
        t = r[i*SW +: SW];
        return int'(t);
    endfunction

    function automatic int f_sum(logic [RW-1:0] r);
        int a = 0;
        for (int i = 0; i < N; i++) a += smp(r, i);
        return a;
    endfunction

    function automatic int f_sad(logic [RW-1:0] r);
        int a = 0;
        for (int i = 1; i < N; i++) begin
            int d = smp(r, i) - smp(r, i-1);
            a += (d < 0) ? -d : d;
        end
        return a;
    endfunction

    function automatic logic [RW-1:0] mk(int v0, int v1, int v2, int v3,
                                         int v4, int v5, int v6, int v7);
        logic [RW-1:0] r;
        r = {SW'(v7), SW'(v6), SW'(v5), SW'(v4), SW'(v3), SW'(v2), SW'(v1), SW'(v0)};
        return r;
    endfunction

    task automatic chk(string req, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one row at a negedge, check the registered result at the next negedge.
    task automatic send(logic [RW-1:0] r, logic [15:0] t, bit clr, string tag);
        int  s, d;
        bit  es;
        string rq;
        row_vld  = 1'b1;
        row_data = r;
        thr      = t;
        cnt_clr  = clr;
        s  = f_sum(r);
        d  = f_sad(r);
        es = (s == 0 && d == 0) || (s != 0 && d < int'(t));
        if (tag != "") rq = tag;
        else if (s == 0 && d == 0) rq = "R2";
        else if (s == 0) rq = "R4";
        else rq = "R3";
        if (clr) exp_cnt = '0;
        else if (es) exp_cnt = exp_cnt + 16'd1;
        @(negedge clk);
        chk("R1", "out_vld", RW'(out_vld), RW'(1));
        chk(rq, "skip", RW'(skip), RW'(es));
        chk(es ? rq : "R5", "out_row", out_row, es ? '0 : r);
        chk("R6", "xfm_en", RW'(xfm_en), RW'(!es));
        chk(clr ? "R9" : "R8", "skip_cnt", RW'(skip_cnt), RW'(exp_cnt));
        cnt_clr = 1'b0;
    endtask

    task automatic idle();
        row_vld  = 1'b0;
        row_data = mk(7, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "out_vld", RW'(out_vld), '0);
        chk("R10", "skip", RW'(skip), '0);
        chk("R10", "xfm_en", RW'(xfm_en), '0);
        chk("R10", "out_row", out_row, '0);
        chk("R10", "skip_cnt", RW'(skip_cnt), RW'(exp_cnt));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        chk("R11", "out_vld", RW'(out_vld), '0);
        chk("R11", "skip", RW'(skip), '0);
        chk("R11", "xfm_en", RW'(xfm_en), '0);
        chk("R11", "out_row", out_row, '0);
        chk("R11", "skip_cnt", RW'(skip_cnt), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all-zero row skips even at thr 0
        send('0, 16'd0, 1'b0, "R2");
        // R3: flat nonzero row, sad 0 not below thr 0, below thr 1
        send(mk(5, 5, 5, 5, 5, 5, 5, 5), 16'd0, 1'b0, "R3");
        send(mk(5, 5, 5, 5, 5, 5, 5, 5), 16'd1, 1'b0, "R3");
        // R4: zero sum, nonzero sad, maximum threshold
        send(mk(1, -1, 0, 0, 0, 0, 0, 0), 16'hFFFF, 1'b0, "R4");
        send(mk(-300, 300, 100, -100, 0, 7, -7, 0), 16'hFFFF, 1'b0, "R4");
        // R3: sad equal to thr kept, one above skipped (sad 6, sum 9)
        send(mk(1, 2, 3, 0, 0, 1, 1, 1), 16'd6, 1'b0, "R3");
        send(mk(1, 2, 3, 0, 0, 1, 1, 1), 16'd7, 1'b0, "R3");
        // R7: full-range alternating row, sad 28665, sum -4
        send(mk(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047), 16'd28665, 1'b0, "R7");
        send(mk(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047), 16'd28666, 1'b0, "R7");
        // R10: idle cycle
        idle();
        // R9: clear wins over a skipped row
        send('0, 16'd0, 1'b1, "R9");
        send('0, 16'd0, 1'b0, "R8");

        for (int k = 0; k < 600; k++) begin
            logic [RW-1:0] r;
            logic [15:0]   t;
            int            m;
            int            base;
            m    = int'($urandom % 5);
            base = int'($urandom % 4096) - 2048;
            r    = '0;
            for (int i = 0; i < N; i++) begin
                int v;
                case (m)
                    0: v = int'($urandom % 4096) - 2048;
                    1: v = base / 2 + int'($urandom % 5) - 2;
                    2: v = (i % 2 == 0) ? base / 2 : -(base / 2);
                    3: v = 0;
                    default: v = int'($urandom % 9) - 4;
                endcase
                r[i*SW +: SW] = SW'(v);
            end
            if (m == 2) r = mk(smp(r,0), smp(r,1), base/3, -(base/3), 11, -11, 0, 0);
            case ($urandom % 3)
                0: t = 16'($urandom);
                1: t = 16'(f_sad(r) + int'($urandom % 3) - 1);
                default: t = 16'($urandom % 64);
            endcase
            send(r, t, ($urandom % 50) == 0, "");
            if (($urandom % 8) == 0) idle();
        end
        idle();
        finish_run();
    end

endmodule